// File: doc/BRIEF.md
# Serial Two's Complement Negator

This block negates a binary word that arrives one bit per clock, least significant bit first, and returns the negated word one bit per clock in the same order. It does not add anything. It uses two modes. In the pass mode each bit leaves unchanged. The first 1 of the word also leaves unchanged, and it switches the block to the flip mode. From then until the word ends, every bit leaves inverted.

The caller sets the word length. It raises a start strobe together with the first bit of each word, or on an idle cycle just before that bit. The strobe puts the block back into pass mode. An input valid qualifies each bit, and only qualified bits move the mode. The parameter `OUT_REG` selects the output stage. With `OUT_REG=0` the output is a true Mealy output in the same cycle as its input bit. With `OUT_REG=1` the same result appears one cycle later from flops.

Top module: `tc_serial_negate`

## Requirements
- R1: While reset is high and for the first cycle after it, the block is in pass mode. With `OUT_REG=1`, `dout_vld` reads 0 out of reset.
- R2: In pass mode, a valid input bit leaves unchanged. This includes the first valid 1 of the word.
- R3: After the first valid 1 of a word, every later valid bit of that word leaves inverted, so the serial output of an N-bit word equals (2^N - value) mod 2^N.
- R4: `word_start` high forces pass mode. This takes effect for a valid bit presented in the same cycle, and also when `word_start` comes on a cycle without valid.
- R5: A cycle with `din_vld` low and `word_start` low leaves the mode unchanged. The following valid bit is treated as if the idle cycle had not occurred.
- R6: `dout_vld` equals `din_vld` of the same cycle when `OUT_REG=0`, and of the previous cycle when `OUT_REG=1`.
- R7: A word of all zeros produces all zeros and leaves the block in pass mode. A following 1 therefore leaves unchanged.
- R8: With `OUT_REG=1`, `dout_bit` equals the bit that the `OUT_REG=0` stage would have produced one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| word_start | input | 1 | Start of word; forces pass mode |
| din_vld | input | 1 | Input bit qualifier |
| din_bit | input | 1 | Serial input bit, least significant bit first |
| dout_vld | output | 1 | Output bit qualifier |
| dout_bit | output | 1 | Serial negated bit |

## Verification
The bench builds two copies of the block side by side from the same stimulus. `dut_i` uses `OUT_REG=0` and its outputs are checked within the cycle. `dut_reg_i` uses `OUT_REG=1` and its outputs are checked just after the next edge. With both copies, the bench compares the same-cycle Mealy path and the one-cycle registered path against one model. That model covers words of several lengths, idle gaps inside a word, and start strobes that arrive with a bit or on an idle cycle.

// File: rtl/tc_pkg.sv
package tc_pkg;
  typedef enum logic {
    TC_PASS = 1'b0,
    TC_FLIP = 1'b1
  } tc_mode_e;
endpackage

// File: rtl/tc_mode_ctrl.sv
module tc_mode_ctrl
  import tc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     word_start,
  input  logic     din_vld,
  input  logic     din_bit,
  output tc_mode_e eff_mode
);
  tc_mode_e mode_q, mode_d;

  // start strobe overrides the stored mode for the bit of the same cycle
  always_comb eff_mode = word_start ? TC_PASS : mode_q;

  always_comb begin
    mode_d = eff_mode;
    if (din_vld && (eff_mode == TC_PASS) && din_bit)
      mode_d = TC_FLIP;
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= TC_PASS;
    else     mode_q <= mode_d;
  end

  // R3: flip mode persists until a new word starts
  a_r3_flip_sticky: assert property (@(posedge clk) disable iff (rst)
    (mode_q == TC_FLIP && !word_start) |=> (mode_q == TC_FLIP));

  // R5: idle cycles do not move the mode
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!din_vld && !word_start) |=> $stable(mode_q));

  // R4: a strobe on an idle cycle leaves pass mode
  a_r4_start_idle: assert property (@(posedge clk) disable iff (rst)
    (word_start && !din_vld) |=> (mode_q == TC_PASS));

  // R7: a zero bit in pass mode stays in pass mode
  a_r7_zero_stays: assert property (@(posedge clk) disable iff (rst)
    (din_vld && !din_bit && eff_mode == TC_PASS) |=> (mode_q == TC_PASS));
endmodule

// File: rtl/tc_out_stage.sv
module tc_out_stage
  import tc_pkg::*;
#(
  parameter bit OUT_REG = 1'b0
)(
  input  logic     clk,
  input  logic     rst,
  input  tc_mode_e eff_mode,
  input  logic     din_vld,
  input  logic     din_bit,
  output logic     dout_vld,
  output logic     dout_bit
);
  logic bit_c;
  always_comb bit_c = (eff_mode == TC_FLIP) ? ~din_bit : din_bit;

  generate
    if (OUT_REG) begin : g_reg
      logic vld_q, bit_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          vld_q <= 1'b0;
          bit_q <= 1'b0;
        end else begin
          vld_q <= din_vld;
          bit_q <= din_vld ? bit_c : 1'b0;
        end
      end
      assign dout_vld = vld_q;
      assign dout_bit = bit_q;

      // R6: registered valid trails input valid by one cycle
      a_r6_vld_delay: assert property (@(posedge clk) disable iff (rst)
        din_vld |=> dout_vld);
      a_r6_idle_delay: assert property (@(posedge clk) disable iff (rst)
        !din_vld |=> !dout_vld);
    end else begin : g_comb
      assign dout_vld = din_vld;
      assign dout_bit = bit_c;

      // R6: same-cycle valid; outputs quiet when idle
      a_r6_vld_same: assert property (@(posedge clk) disable iff (rst)
        !din_vld |-> !dout_vld);
    end
  endgenerate
endmodule

// File: rtl/tc_serial_negate.sv
module tc_serial_negate
  import tc_pkg::*;
#(
  parameter bit OUT_REG = 1'b0
)(
  input  logic clk,
  input  logic rst,
  input  logic word_start,
  input  logic din_vld,
  input  logic din_bit,
  output logic dout_vld,
  output logic dout_bit
);
  tc_mode_e eff_mode;

  tc_mode_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .word_start (word_start),
    .din_vld    (din_vld),
    .din_bit    (din_bit),
    .eff_mode   (eff_mode)
  );

  tc_out_stage #(.OUT_REG(OUT_REG)) u_out (
    .clk      (clk),
    .rst      (rst),
    .eff_mode (eff_mode),
    .din_vld  (din_vld),
    .din_bit  (din_bit),
    .dout_vld (dout_vld),
    .dout_bit (dout_bit)
  );

  // R4: the first bit of a word always leaves unchanged
  a_r4_first_bit_pass: assert property (@(posedge clk) disable iff (rst)
    (OUT_REG == 1'b0 && word_start && din_vld) |-> (dout_bit == din_bit));

  // R8: registered output carries the first bit of a word unchanged
  a_r8_first_bit_reg: assert property (@(posedge clk) disable iff (rst)
    (OUT_REG == 1'b1 && word_start && din_vld) |=> (dout_bit == $past(din_bit)));
endmodule

// File: tb/tc_serial_negate_tb_top.sv
`timescale 1ns/1ps
module tc_serial_negate_tb_top;
  logic clk = 1'b0;
  logic rst, word_start, din_vld, din_bit;
  logic c_vld, c_bit, r_vld, r_bit;
  int   checks = 0, failures = 0;
  bit   seen_one = 1'b0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  tc_serial_negate #(.OUT_REG(1'b0)) dut_i (
    .clk(clk), .rst(rst), .word_start(word_start), .din_vld(din_vld),
    .din_bit(din_bit), .dout_vld(c_vld), .dout_bit(c_bit));

  tc_serial_negate #(.OUT_REG(1'b1)) dut_reg_i (
    .clk(clk), .rst(rst), .word_start(word_start), .din_vld(din_vld),
    .din_bit(din_bit), .dout_vld(r_vld), .dout_bit(r_bit));

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // drive one cycle; check same-cycle copy, then registered copy after the edge
  task automatic step(input logic st, input logic v, input logic b,
                      input string tag, output logic got);
    logic exp_bit;
    @(negedge clk);
    word_start = st; din_vld = v; din_bit = b;
    if (st) seen_one = 1'b0;
    exp_bit = seen_one ? ~b : b;
    #1;
    check({tag, " R6 comb vld"}, c_vld, v);
    if (v) check({tag, " comb bit"}, c_bit, exp_bit);
    got = c_bit;
    if (v && b) seen_one = 1'b1;
    @(posedge clk); #1;
    check({tag, " R6 reg vld"}, r_vld, v);
    if (v) check({tag, " R8 reg bit"}, r_bit, exp_bit);
  endtask

  task automatic idle(input string tag);
    logic g;
    step(1'b0, 1'b0, 1'b0, tag, g);
  endtask

  task automatic send_word(input logic [15:0] val, input int n, input string tag);
    logic [15:0] res, mask;
    logic g;
    res = '0;
    mask = (n == 16) ? 16'hFFFF : ((16'd1 << n) - 16'd1);
    for (int i = 0; i < n; i++) begin
      step(i == 0, 1'b1, val[i], tag, g);
      res[i] = g;
    end
    checks++;
    if (res !== ((~val + 16'd1) & mask)) begin
      failures++;
      $display("FAIL %s R3 word actual=%h expected=%h", tag, res,
               (~val + 16'd1) & mask);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; word_start = 1'b0; din_vld = 1'b0; din_bit = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reg vld in reset", r_vld, 1'b0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    check("R1 reg vld after reset", r_vld, 1'b0);
    check("R1 comb vld after reset", c_vld, 1'b0);
    begin
      logic g;
      seen_one = 1'b0;
      step(1'b0, 1'b1, 1'b1, "R1 pass mode after reset", g);
      check("R1 first bit unchanged", g, 1'b1);
    end
  endtask

  task automatic t_words();
    send_word(16'h0034, 7, "R2 R3 w7");
    send_word(16'h0001, 4, "R2 R3 single one");
    send_word(16'hA5C8, 16, "R3 w16");
    send_word(16'h0080, 8, "R3 msb only");
  endtask

  task automatic t_zero();
    logic g;
    send_word(16'h0000, 6, "R7 zeros");
    step(1'b0, 1'b1, 1'b1, "R7 pass kept", g);
    check("R7 one after zeros unchanged", g, 1'b1);
  endtask

  task automatic t_gaps();
    logic g;
    step(1'b1, 1'b1, 1'b0, "R5 gap", g);
    idle("R5 gap idle");
    step(1'b0, 1'b1, 1'b1, "R5 gap", g);
    check("R5 one after idle unchanged", g, 1'b1);
    idle("R5 gap idle");
    idle("R5 gap idle");
    step(1'b0, 1'b1, 1'b1, "R5 gap", g);
    check("R5 flip kept over idle", g, 1'b0);
  endtask

  task automatic t_start();
    logic g;
    step(1'b1, 1'b1, 1'b1, "R4 setup", g);
    step(1'b0, 1'b1, 1'b0, "R4 setup", g);
    check("R4 flipping before start", g, 1'b1);
    step(1'b1, 1'b1, 1'b1, "R4 start with bit", g);
    check("R4 start same-cycle pass", g, 1'b1);
    step(1'b0, 1'b1, 1'b1, "R4 flip again", g);
    check("R4 flip after first one", g, 1'b0);
    step(1'b1, 1'b0, 1'b0, "R4 start idle", g);
    step(1'b0, 1'b1, 1'b1, "R4 after idle start", g);
    check("R4 idle start forces pass", g, 1'b1);
  endtask

  initial begin
    t_reset();
    t_words();
    t_zero();
    t_gaps();
    t_start();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule